// File: doc/BRIEF.md
# EOI Storm Controller

This block retires level-triggered interrupts when an end-of-interrupt (EOI) arrives. An EOI carries an 8-bit vector. It comes either as a broadcast from the local interrupt controller or as an explicit register write. An explicit write is qualified by its access size and the controller version. An accepted EOI starts a sweep over the redirection table, one pin per clock. On each pin whose vector equals the EOI vector, whose trigger is level and whose remote-IRR is set, the sweep clears remote-IRR.

When such a pin is unmasked and its input is still pending, the interrupt would be re-delivered straight away. A per-pin counter tracks these back-to-back re-assertions. While the counter is below a threshold, the block pulses a service request at once. When the counter reaches the threshold, it returns to zero and the service request is pushed out by a single shared deferral timer. A handler that never quiets its source can therefore still make progress.

The redirection block feeds the table through a configuration write port, remote-IRR set strobes and pending set/clear strobes. It reads the table back through an indexed read port, and it acts on the service-request pulse.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: A pin is affected by a sweep only when its vector equals the EOI vector, its trigger is level (1) and its remote-IRR is set; every other pin keeps its remote-IRR and counter unchanged.
- R2: A matching pin has its remote-IRR cleared.
- R3: A matching pin that is unmasked (mask 0) and pending has its counter incremented. Any other matching pin has its counter set to zero.
- R4: When the incremented count would reach LIMIT, the counter is set to zero, no immediate request is made and the deferral timer is armed. The timer produces a one-cycle svc_req_o pulse DELAY cycles after the arming edge.
- R5: Below LIMIT, a matching unmasked pending pin produces a one-cycle svc_req_o pulse in the cycle after the one in which the sweep visits it.
- R6: A broadcast EOI (eoi_explicit_i=0) is always accepted. An explicit EOI is accepted only when eoi_bytes_i is 4 and version_i is 8'h20; otherwise it has no effect.
- R7: A configuration write to a pin sets its counter to zero. It keeps remote-IRR when the new trigger is level and clears it when the new trigger is edge (0).
- R8: An accepted EOI raises busy_o for exactly N cycles, and pins are visited in order 0 to N-1, one per cycle. An EOI that arrives while busy_o is high is ignored.
- R9: A deferral request that arrives while the timer is running keeps the earlier expiry.
- R10: After reset every pin has vector 0, edge trigger, mask 1, remote-IRR 0, pending 0 and counter 0, and busy_o and svc_req_o are low.
- R11: rirr_set_i sets remote-IRR only on pins configured level; edge pins ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eoi_valid_i | input | 1 | EOI strobe |
| eoi_vector_i | input | 8 | EOI vector |
| eoi_explicit_i | input | 1 | 1 = explicit register write, 0 = broadcast |
| eoi_bytes_i | input | 3 | Access size in bytes of an explicit EOI |
| version_i | input | 8 | Controller version |
| cfg_we_i | input | 1 | Redirection entry write strobe |
| cfg_pin_i | input | $clog2(N) | Pin written |
| cfg_vector_i | input | 8 | New vector |
| cfg_level_i | input | 1 | New trigger, 1 = level |
| cfg_mask_i | input | 1 | New mask |
| rirr_set_i | input | N | Per-pin remote-IRR set strobes |
| pend_set_i | input | N | Per-pin pending set strobes |
| pend_clr_i | input | N | Per-pin pending clear strobes (clear wins) |
| rd_pin_i | input | $clog2(N) | Read index |
| rd_vector_o | output | 8 | Vector of read pin |
| rd_level_o | output | 1 | Trigger of read pin |
| rd_mask_o | output | 1 | Mask of read pin |
| rd_rirr_o | output | 1 | Remote-IRR of read pin |
| rd_pend_o | output | 1 | Pending bit of read pin |
| rd_count_o | output | $clog2(LIMIT+1) | Successive-EOI counter of read pin |
| busy_o | output | 1 | Sweep in progress |
| svc_req_o | output | 1 | Service request pulse |

## Verification
If an EOI is sampled at edge k, busy_o rises after edge k and falls after edge k+N. Pin p is visited at edge k+1+p, so its new remote-IRR and counter, and any immediate svc_req_o pulse, appear right after that edge. A deferred request appears right after edge E+DELAY, where E is the arming edge. The bench's behavioural model advances on the same edges, and every output is compared half a cycle later. The read index rotates during idle stretches so that all entries are compared, and directed peeks check literal values at the end of each sweep.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  localparam int VEC_W = 8;
  localparam logic [7:0] EXPLICIT_VER = 8'h20;
  localparam logic [2:0] EXPLICIT_BYTES = 3'd4;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             level;
    logic             mask;
    logic             rirr;
  } rte_t;

  localparam rte_t RTE_RST = '{vec: '0, level: 1'b0, mask: 1'b1, rirr: 1'b0};
endpackage

// File: rtl/eoi_pin_slot.sv
module eoi_pin_slot
  import eoi_pkg::*;
#(
  parameter int LIMIT = 10000,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [VEC_W-1:0] cfg_vec_i,
  input  logic             cfg_level_i,
  input  logic             cfg_mask_i,
  input  logic             rirr_set_i,
  input  logic             pend_set_i,
  input  logic             pend_clr_i,
  input  logic             visit_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output rte_t             ent_o,
  output logic             pend_o,
  output logic [CW-1:0]    cnt_o,
  output logic             fire_now_o,
  output logic             fire_defer_o
);
  rte_t          ent_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q, cnt_inc;
  logic          match, hot, storm, rirr_nxt;

  assign match   = visit_i && ent_q.level && ent_q.rirr && (ent_q.vec == eoi_vec_i);
  assign hot     = match && !ent_q.mask && pend_q;
  assign cnt_inc = cnt_q + 1'b1;
  assign storm   = hot && (cnt_inc >= CW'(LIMIT));
  assign fire_now_o   = hot && !storm;
  assign fire_defer_o = storm;

  // set strobe only lands on level entries
  assign rirr_nxt = (match ? 1'b0 : ent_q.rirr) | (rirr_set_i & ent_q.level);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q  <= RTE_RST;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we_i) begin
        ent_q.vec   <= cfg_vec_i;
        ent_q.level <= cfg_level_i;
        ent_q.mask  <= cfg_mask_i;
        ent_q.rirr  <= cfg_level_i & (ent_q.rirr | rirr_set_i);
        cnt_q       <= '0;
      end else begin
        ent_q.rirr <= rirr_nxt;
        if (match) cnt_q <= fire_now_o ? cnt_inc : '0;
      end
      if (pend_clr_i)      pend_q <= 1'b0;
      else if (pend_set_i) pend_q <= 1'b1;
    end
  end

  assign ent_o  = ent_q;
  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

  a_r3_cnt_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));
  a_r2_match_clears_rirr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !cfg_we_i && !rirr_set_i) |=> !ent_q.rirr);
  a_r7_cfg_zeroes_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cnt_q == '0));
  a_r1_nomatch_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (visit_i && !match && !cfg_we_i && !rirr_set_i) |=> ($stable(ent_q) && $stable(cnt_q)));
endmodule

// File: rtl/eoi_sweep.sv
module eoi_sweep
  import eoi_pkg::*;
#(
  parameter int N  = 24,
  parameter int PW = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             eoi_explicit_i,
  input  logic [2:0]       eoi_bytes_i,
  input  logic [7:0]       version_i,
  output logic             busy_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     visit_o
);
  logic             busy_q;
  logic [PW-1:0]    idx_q;
  logic [VEC_W-1:0] vec_q;
  logic             eoi_ok, last;

  assign eoi_ok = eoi_valid_i &&
                  (!eoi_explicit_i || (eoi_bytes_i == EXPLICIT_BYTES && version_i == EXPLICIT_VER));
  assign last   = (idx_q == PW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (eoi_ok) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      vec_q  <= eoi_vector_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_visit
    assign visit_o[g] = busy_q && (idx_q == PW'(g));
  end

  assign busy_o = busy_q;
  assign vec_o  = vec_q;

  a_r8_sweep_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last) |=> !busy_q);
  a_r8_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (idx_q == '0));
  a_r8_single_visit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(visit_o));
  a_r6_bad_size_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && eoi_valid_i && eoi_explicit_i && eoi_bytes_i != EXPLICIT_BYTES) |=> !busy_q);
endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
  parameter int DELAY = 1000000,
  parameter int TW    = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic now_i,
  output logic svc_req_o
);
  logic [TW-1:0] tmr_q;
  logic          expire, svc_q;

  assign expire = (tmr_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      svc_q <= 1'b0;
    end else begin
      svc_q <= now_i | expire;
      // a running timer keeps its expiry
      if (arm_i && tmr_q <= TW'(1)) tmr_q <= TW'(DELAY);
      else if (tmr_q != '0)         tmr_q <= tmr_q - 1'b1;
    end
  end

  assign svc_req_o = svc_q;

  a_r9_keeps_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q > TW'(1)) |=> (tmr_q == $past(tmr_q) - 1'b1));
  a_r4_expiry_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> svc_q);
  a_r5_immediate_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_i |=> svc_q);
endmodule

// File: rtl/eoi_storm_ctrl.sv
module eoi_storm_ctrl
  import eoi_pkg::*;
#(
  parameter int N     = 24,
  parameter int LIMIT = 10000,
  parameter int DELAY = 1000000,
  localparam int PW   = $clog2(N),
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eoi_valid_i,
  input  logic [7:0]    eoi_vector_i,
  input  logic          eoi_explicit_i,
  input  logic [2:0]    eoi_bytes_i,
  input  logic [7:0]    version_i,
  input  logic          cfg_we_i,
  input  logic [PW-1:0] cfg_pin_i,
  input  logic [7:0]    cfg_vector_i,
  input  logic          cfg_level_i,
  input  logic          cfg_mask_i,
  input  logic [N-1:0]  rirr_set_i,
  input  logic [N-1:0]  pend_set_i,
  input  logic [N-1:0]  pend_clr_i,
  input  logic [PW-1:0] rd_pin_i,
  output logic [7:0]    rd_vector_o,
  output logic          rd_level_o,
  output logic          rd_mask_o,
  output logic          rd_rirr_o,
  output logic          rd_pend_o,
  output logic [CW-1:0] rd_count_o,
  output logic          busy_o,
  output logic          svc_req_o
);
  rte_t             ent   [N];
  logic [CW-1:0]    cnt   [N];
  logic [N-1:0]     pend, now_v, defer_v, visit;
  logic [VEC_W-1:0] sweep_vec;

  eoi_sweep #(.N(N)) u_sweep (
    .clk_i, .rst_ni,
    .eoi_valid_i, .eoi_vector_i, .eoi_explicit_i, .eoi_bytes_i, .version_i,
    .busy_o, .vec_o(sweep_vec), .visit_o(visit)
  );

  for (genvar g = 0; g < N; g++) begin : g_pin
    eoi_pin_slot #(.LIMIT(LIMIT), .CW(CW)) u_slot (
      .clk_i, .rst_ni,
      .cfg_we_i    (cfg_we_i && (cfg_pin_i == PW'(g))),
      .cfg_vec_i   (cfg_vector_i),
      .cfg_level_i (cfg_level_i),
      .cfg_mask_i  (cfg_mask_i),
      .rirr_set_i  (rirr_set_i[g]),
      .pend_set_i  (pend_set_i[g]),
      .pend_clr_i  (pend_clr_i[g]),
      .visit_i     (visit[g]),
      .eoi_vec_i   (sweep_vec),
      .ent_o       (ent[g]),
      .pend_o      (pend[g]),
      .cnt_o       (cnt[g]),
      .fire_now_o  (now_v[g]),
      .fire_defer_o(defer_v[g])
    );
  end

  eoi_defer_timer #(.DELAY(DELAY)) u_timer (
    .clk_i, .rst_ni,
    .arm_i    (|defer_v),
    .now_i    (|now_v),
    .svc_req_o
  );

  always_comb begin
    rd_vector_o = '0;
    rd_level_o  = 1'b0;
    rd_mask_o   = 1'b0;
    rd_rirr_o   = 1'b0;
    rd_pend_o   = 1'b0;
    rd_count_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_pin_i == PW'(i)) begin
        rd_vector_o = ent[i].vec;
        rd_level_o  = ent[i].level;
        rd_mask_o   = ent[i].mask;
        rd_rirr_o   = ent[i].rirr;
        rd_pend_o   = pend[i];
        rd_count_o  = cnt[i];
      end
    end
  end

  a_r4_no_dual_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|now_v) && (|defer_v)));
  a_r8_fire_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|now_v) || (|defer_v)) |-> busy_o);
endmodule

// File: tb/eoi_storm_ctrl_bench.sv
`timescale 1ns/1ps
module eoi_storm_ctrl_bench;
  localparam int N = 24, LIMIT = 4, DELAY = 200, PW = $clog2(N), CW = $clog2(LIMIT + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic eoi_valid_i = 0, eoi_explicit_i = 0, cfg_we_i = 0, cfg_level_i = 0, cfg_mask_i = 0;
  logic [7:0] eoi_vector_i = 0, version_i = 8'h20, cfg_vector_i = 0;
  logic [2:0] eoi_bytes_i = 3'd4;
  logic [PW-1:0] cfg_pin_i = 0, rd_pin_i = 0;
  logic [N-1:0] rirr_set_i = 0, pend_set_i = 0, pend_clr_i = 0;
  logic [7:0] rd_vector_o;
  logic rd_level_o, rd_mask_o, rd_rirr_o, rd_pend_o, busy_o, svc_req_o;
  logic [CW-1:0] rd_count_o;

  always #2.5 clk_i = ~clk_i;

  eoi_storm_ctrl #(.N(N), .LIMIT(LIMIT), .DELAY(DELAY)) u_eoi_storm_ctrl (.*);

  int n_chk = 0, n_fail = 0, svc_seen = 0;
  bit cmp_en = 0, rot = 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_vec[N], m_lvl[N], m_msk[N], m_rirr[N], m_pend[N], m_cnt[N];
  int m_busy, m_idx, m_evec, m_tmr, m_svc;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (m_vec[i]) begin
        m_vec[i] = 0; m_lvl[i] = 0; m_msk[i] = 1; m_rirr[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
      end
      m_busy = 0; m_idx = 0; m_evec = 0; m_tmr = 0; m_svc = 0;
    end else begin
      int vp, now, dfr, mt;
      bit ok;
      vp = m_busy ? m_idx : -1;
      now = 0; dfr = 0; mt = 0;
      if (vp >= 0 && m_vec[vp] == m_evec && m_lvl[vp] == 1 && m_rirr[vp] == 1) begin
        mt = 1;
        if (m_msk[vp] == 0 && m_pend[vp] == 1) begin
          if (m_cnt[vp] + 1 >= LIMIT) dfr = 1; else now = 1;
        end
      end
      m_svc = (now == 1 || m_tmr == 1) ? 1 : 0;
      if (dfr == 1 && m_tmr <= 1) m_tmr = DELAY;
      else if (m_tmr > 0) m_tmr--;
      for (int i = 0; i < N; i++) begin
        if (cfg_we_i && int'(cfg_pin_i) == i) begin
          m_vec[i] = cfg_vector_i; m_lvl[i] = cfg_level_i; m_msk[i] = cfg_mask_i; m_cnt[i] = 0;
          if (!cfg_level_i) m_rirr[i] = 0;
        end else if (i == vp && mt == 1) begin
          m_rirr[i] = 0;
          m_cnt[i] = (now == 1) ? m_cnt[i] + 1 : 0;
        end
        if (rirr_set_i[i] && m_lvl[i] == 1) m_rirr[i] = 1;
        if (pend_clr_i[i]) m_pend[i] = 0;
        else if (pend_set_i[i]) m_pend[i] = 1;
      end
      ok = eoi_valid_i && (!eoi_explicit_i || (eoi_bytes_i == 3'd4 && version_i == 8'h20));
      if (m_busy == 1) begin
        if (m_idx == N - 1) begin m_busy = 0; m_idx = 0; end
        else m_idx++;
      end else if (ok) begin
        m_busy = 1; m_idx = 0; m_evec = eoi_vector_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && cmp_en) begin
      int p;
      p = int'(rd_pin_i);
      chk("R4 R5 R9 svc_req_o", int'(svc_req_o), m_svc);
      chk("R6 R8 busy_o", int'(busy_o), m_busy);
      chk("R7 vector", int'(rd_vector_o), m_vec[p]);
      chk("R7 level", int'(rd_level_o), m_lvl[p]);
      chk("R7 mask", int'(rd_mask_o), m_msk[p]);
      chk("R1 R2 R11 rirr", int'(rd_rirr_o), m_rirr[p]);
      chk("R3 pend", int'(rd_pend_o), m_pend[p]);
      chk("R3 R4 R7 count", int'(rd_count_o), m_cnt[p]);
    end
    if (rst_ni && svc_req_o) svc_seen++;
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk_i); #1;
      if (rot) rd_pin_i = (int'(rd_pin_i) == N - 1) ? '0 : rd_pin_i + 1'b1;
    end
  endtask

  task automatic cfg(int pin, int vec, bit lvl, bit msk);
    cfg_we_i = 1; cfg_pin_i = PW'(pin); cfg_vector_i = 8'(vec); cfg_level_i = lvl; cfg_mask_i = msk;
    step(); cfg_we_i = 0;
  endtask

  task automatic set_rirr(logic [N-1:0] v);
    rirr_set_i = v; step(); rirr_set_i = '0;
  endtask

  task automatic set_pend(logic [N-1:0] v, logic [N-1:0] c);
    pend_set_i = v; pend_clr_i = c; step(); pend_set_i = '0; pend_clr_i = '0;
  endtask

  task automatic eoi(int vec, bit expl, int bytes);
    eoi_valid_i = 1; eoi_vector_i = 8'(vec); eoi_explicit_i = expl; eoi_bytes_i = 3'(bytes);
    step(); eoi_valid_i = 0; eoi_explicit_i = 0; eoi_bytes_i = 3'd4;
    step(N + 2);
  endtask

  task automatic peek(string tag, int pin, int rirr, int pend, int cnt);
    rot = 0; rd_pin_i = PW'(pin);
    @(negedge clk_i);
    chk({tag, " peek rirr"}, int'(rd_rirr_o), rirr);
    chk({tag, " peek pend"}, int'(rd_pend_o), pend);
    chk({tag, " peek count"}, int'(rd_count_o), cnt);
    step(); rot = 1;
  endtask

  task automatic run();
    int base;
    step(3);
    @(negedge clk_i);
    chk("R10 reset busy", int'(busy_o), 0);
    chk("R10 reset svc", int'(svc_req_o), 0);
    chk("R10 reset mask", int'(rd_mask_o), 1);
    rst_ni = 1; cmp_en = 1;
    step(2);
    peek("R10", 0, 0, 0, 0);
    cfg(3, 'h40, 1, 0); cfg(5, 'h40, 0, 0); cfg(7, 'h41, 1, 0); cfg(9, 'h40, 1, 1);
    set_rirr((N'(1) << 3) | (N'(1) << 5) | (N'(1) << 7) | (N'(1) << 9));
    set_pend((N'(1) << 3) | (N'(1) << 9), '0);
    peek("R11 edge pin", 5, 0, 0, 0);
    base = svc_seen;
    eoi('h40, 0, 4);
    chk("R5 one immediate request", svc_seen - base, 1);
    peek("R2 R3 pin3", 3, 0, 1, 1);
    peek("R1 pin7 other vector", 7, 1, 0, 0);
    peek("R3 masked pin9", 9, 0, 1, 0);
    eoi('h41, 1, 2);
    peek("R6 short explicit", 7, 1, 0, 0);
    version_i = 8'h11;
    eoi('h41, 1, 4);
    peek("R6 old version", 7, 1, 0, 0);
    version_i = 8'h20;
    eoi('h41, 1, 4);
    peek("R6 explicit accepted", 7, 0, 0, 0);
    set_rirr((N'(1) << 3) | (N'(1) << 7));
    eoi_valid_i = 1; eoi_vector_i = 8'h40; step();
    eoi_vector_i = 8'h41; step(); eoi_valid_i = 0;
    step(N + 2);
    peek("R8 eoi during sweep ignored", 7, 1, 0, 0);
    peek("R8 first eoi served", 3, 0, 1, 2);
    base = svc_seen;
    set_rirr(N'(1) << 3); eoi('h40, 0, 4);
    peek("R5 pin3 third", 3, 0, 1, 3);
    set_rirr(N'(1) << 3); eoi('h40, 0, 4);
    peek("R4 pin3 storm resets", 3, 0, 1, 0);
    chk("R4 no immediate at storm", svc_seen - base, 1);
    cfg(11, 'h50, 1, 0); set_pend(N'(1) << 11, '0);
    for (int r = 0; r < LIMIT; r++) begin
      set_rirr(N'(1) << 11); eoi('h50, 0, 4);
    end
    peek("R4 pin11 storm resets", 11, 0, 1, 0);
    step(DELAY + 10);
    chk("R9 single deferred request", svc_seen - base, 1 + (LIMIT - 1) + 1);
    set_rirr(N'(1) << 3); eoi('h40, 0, 4);
    peek("R5 pin3 restart", 3, 0, 1, 1);
    cfg(3, 'h40, 1, 0);
    peek("R7 rewrite zeroes count", 3, 0, 1, 0);
    set_rirr(N'(1) << 3);
    cfg(3, 'h40, 0, 0);
    peek("R7 edge clears rirr", 3, 0, 1, 0);
    set_pend('0, N'(1) << 3); cfg(3, 'h40, 1, 0); set_rirr(N'(1) << 3);
    base = svc_seen;
    eoi('h40, 0, 4);
    chk("R3 not pending no request", svc_seen - base, 0);
    peek("R3 not pending", 3, 0, 0, 0);
    step(5);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule